// File: doc/BRIEF.md
# Multi-Channel Countdown Timer Peripheral

This peripheral holds a parameterised number of independent 32-bit countdown timers behind a plain register bus. The bus has an address, a write strobe, write data and a read-data output that is combinational on the address. Each channel has a control word, an interval (reload) word and a live count word. The control word picks one of four tick-enable inputs as the clock source and sets a power-of-two prescaler. The channel then counts down once per prescaled tick.

When a channel's count runs out, its pending flag in the shared status register is set. A periodic channel reloads from its interval word and keeps running. A one-shot channel parks at zero and turns itself off. A shared enable mask gates the pending flags onto a single level-sensitive interrupt pin. Software clears a flag by writing a one to its bit.

Software can schedule an event in two ways. It can write the live count word directly. It can also set the load bit in the control word, which copies the interval word into the count.

Top module: `tmr_block`

## Requirements
- R1: After reset every register reads zero, all channels are disabled and `irq` is low.
- R2: The enable mask is at byte offset 0x00 and the status register is at 0x04, with bit n belonging to channel n. Channel n has its control word at 0x10·n+0x10, its interval at 0x10·n+0x14 and its count at 0x10·n+0x18. Any other address reads zero, and writes to it change nothing.
- R3: Control fields are: bit 0 enable, bit 1 load, bits 3:2 source select (tick input index), bits 6:4 prescale code and bit 7 one-shot. Writing load=1 copies the interval into the count. The load bit and bits 31:8 read back as zero.
- R4: While enabled, the count drops by one on each prescaled tick of the selected source. A disabled channel, or a pulse on any other source, leaves the count unchanged.
- R5: Prescale code k passes one tick for every 2^k source pulses, so code 2 divides by 4 and code 4 divides by 16. The divider restarts from zero whenever the channel is disabled.
- R6: A tick that arrives while the count is 1 or 0 is an expiry and sets the channel's status bit. If one-shot is clear, the count reloads from the interval on that same edge.
- R7: On expiry with one-shot set, the count becomes 0 and the enable bit clears, so further ticks have no effect.
- R8: A bus write to the count word loads it directly.
- R9: Writing 1 to a status bit clears it, and writing 0 leaves it unchanged.
- R10: If an expiry and a write-1-to-clear hit the same status bit in one cycle, the bit ends up set.
- R11: `irq` is high exactly when some channel has both its status bit and its enable-mask bit set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | ADDR_W (8) | Byte address of the register access |
| bus_we | input | 1 | Write strobe, sampled on the rising edge |
| bus_wdata | input | DATA_W (32) | Write data |
| bus_rdata | output | DATA_W (32) | Read data for `bus_addr`, combinational |
| src_tick | input | 4 | Tick-enable pulses, one per selectable source |
| irq | output | 1 | Level interrupt: OR of pending-and-enabled flags |

## Verification
The bench drives the expiry edge itself and then reads the count. A design that treats the terminal count as 0 instead of 1 would reload one tick late, and one that ignores one-shot would keep counting after the first event. Status is cleared in the same cycle as an expiry; a design that lets the clear win would lose the event and drop the interrupt. The divide-by-4 and divide-by-16 codes are checked on the pulse just before the boundary and on the boundary pulse, which catches an off-by-one in the divider mask. Pulses on an unselected source and accesses to unmapped addresses must leave every readable count unchanged.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int SRC_W  = 2;
  localparam int NSRC   = 1 << SRC_W;
  localparam int PRE_W  = 3;

  // word offsets inside a 16-byte page
  localparam logic [3:0] OFF_IEN  = 4'h0;
  localparam logic [3:0] OFF_STAT = 4'h4;
  localparam logic [3:0] OFF_CTRL = 4'h0;
  localparam logic [3:0] OFF_INTV = 4'h4;
  localparam logic [3:0] OFF_CNT  = 4'h8;

  typedef struct packed {
    logic             oneshot;  // bit 7
    logic [PRE_W-1:0] pre;      // bits 6:4
    logic [SRC_W-1:0] src;      // bits 3:2
    logic             load;     // bit 1, self-clearing
    logic             en;       // bit 0
  } ctrl_t;

  localparam int CTRL_W = $bits(ctrl_t);
endpackage

// File: rtl/tmr_prescale.sv
module tmr_prescale #(
  parameter int PRE_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             raw,
  input  logic [PRE_W-1:0] code,
  output logic             tick
);
  localparam int DIV_W = (1 << PRE_W) - 1;

  logic [DIV_W-1:0] div_q;
  logic [DIV_W-1:0] mask;

  assign mask = ~({DIV_W{1'b1}} << code);
  assign tick = en && raw && ((div_q & mask) == mask);

  always_ff @(posedge clk) begin
    if (!rst_n || !en) div_q <= '0;
    else if (raw)      div_q <= div_q + 1'b1;
  end

  // R5: a tick only leaves when the divider is at its terminal phase
  a_r5_tick_phase: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> (en ? ((div_q & mask) == '0) : 1'b1));
endmodule

// File: rtl/tmr_channel.sv
module tmr_channel
  import tmr_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NSRC-1:0]   src_tick,
  input  logic              wr_ctrl,
  input  logic              wr_intv,
  input  logic              wr_cnt,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] ctrl_rd,
  output logic [DATA_W-1:0] intv_rd,
  output logic [DATA_W-1:0] cnt_rd,
  output logic              expire
);
  ctrl_t             ctrl_q;
  ctrl_t             ctrl_wr;
  logic [DATA_W-1:0] intv_q;
  logic [DATA_W-1:0] cnt_q;
  logic              raw;
  logic              tick;
  logic              load_now;

  always_comb begin
    ctrl_wr      = ctrl_t'(wdata[CTRL_W-1:0]);
    ctrl_wr.load = 1'b0;
  end

  assign raw      = src_tick[ctrl_q.src];
  assign load_now = wr_ctrl && wdata[1];
  assign expire   = tick && (cnt_q <= DATA_W'(1));

  tmr_prescale #(.PRE_W(PRE_W)) u_pre (
    .clk  (clk),
    .rst_n(rst_n),
    .en   (ctrl_q.en),
    .raw  (raw),
    .code (ctrl_q.pre),
    .tick (tick)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      intv_q <= '0;
      cnt_q  <= '0;
    end else begin
      if (wr_ctrl)                        ctrl_q    <= ctrl_wr;
      else if (expire && ctrl_q.oneshot)  ctrl_q.en <= 1'b0;

      if (wr_intv) intv_q <= wdata;

      if (wr_cnt)        cnt_q <= wdata;
      else if (load_now) cnt_q <= intv_q;
      else if (expire)   cnt_q <= ctrl_q.oneshot ? '0 : intv_q;
      else if (tick)     cnt_q <= cnt_q - 1'b1;
    end
  end

  assign ctrl_rd = {{(DATA_W-CTRL_W){1'b0}}, ctrl_q};
  assign intv_rd = intv_q;
  assign cnt_rd  = cnt_q;

  // R4: without a tick or a bus write the count holds
  a_r4_count_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !wr_cnt && !wr_ctrl) |=> $stable(cnt_q));

  // R6: periodic expiry reloads the interval
  a_r6_periodic_reload: assert property (@(posedge clk) disable iff (!rst_n)
    (expire && !ctrl_q.oneshot && !wr_cnt && !load_now) |=> (cnt_q == $past(intv_q)));

  // R7: one-shot expiry stops the channel at zero
  a_r7_oneshot_stops: assert property (@(posedge clk) disable iff (!rst_n)
    (expire && ctrl_q.oneshot && !wr_ctrl && !wr_cnt) |=> (!ctrl_q.en && cnt_q == '0));
endmodule

// File: rtl/tmr_block.sv
module tmr_block
  import tmr_pkg::*;
#(
  parameter int NTMR   = 2,
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [NSRC-1:0]   src_tick,
  output logic              irq
);
  localparam int PAGE_W = ADDR_W - 4;

  logic [PAGE_W-1:0] page;
  logic [3:0]        off;
  logic [NTMR-1:0]   ien_q;
  logic [NTMR-1:0]   stat_q;
  logic [NTMR-1:0]   w1c;
  logic [NTMR-1:0]   ch_exp;
  logic [DATA_W-1:0] ch_ctrl [NTMR];
  logic [DATA_W-1:0] ch_intv [NTMR];
  logic [DATA_W-1:0] ch_cnt  [NTMR];
  logic              wr_ien;
  logic              wr_stat;

  assign page    = bus_addr[ADDR_W-1:4];
  assign off     = bus_addr[3:0];
  assign wr_ien  = bus_we && (page == '0) && (off == OFF_IEN);
  assign wr_stat = bus_we && (page == '0) && (off == OFF_STAT);
  assign w1c     = wr_stat ? bus_wdata[NTMR-1:0] : '0;

  for (genvar i = 0; i < NTMR; i++) begin : g_ch
    logic pg_hit;
    assign pg_hit = bus_we && (page == PAGE_W'(i + 1));

    tmr_channel #(.DATA_W(DATA_W)) u_ch (
      .clk     (clk),
      .rst_n   (rst_n),
      .src_tick(src_tick),
      .wr_ctrl (pg_hit && (off == OFF_CTRL)),
      .wr_intv (pg_hit && (off == OFF_INTV)),
      .wr_cnt  (pg_hit && (off == OFF_CNT)),
      .wdata   (bus_wdata),
      .ctrl_rd (ch_ctrl[i]),
      .intv_rd (ch_intv[i]),
      .cnt_rd  (ch_cnt[i]),
      .expire  (ch_exp[i])
    );
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ien_q  <= '0;
      stat_q <= '0;
    end else begin
      if (wr_ien) ien_q <= bus_wdata[NTMR-1:0];
      stat_q <= (stat_q & ~w1c) | ch_exp;
    end
  end

  assign irq = |(stat_q & ien_q);

  always_comb begin
    bus_rdata = '0;
    if (page == '0) begin
      if (off == OFF_IEN)  bus_rdata = {{(DATA_W-NTMR){1'b0}}, ien_q};
      if (off == OFF_STAT) bus_rdata = {{(DATA_W-NTMR){1'b0}}, stat_q};
    end
    for (int i = 0; i < NTMR; i++) begin
      if (page == PAGE_W'(i + 1)) begin
        if (off == OFF_CTRL) bus_rdata = ch_ctrl[i];
        if (off == OFF_INTV) bus_rdata = ch_intv[i];
        if (off == OFF_CNT)  bus_rdata = ch_cnt[i];
      end
    end
  end

  // R10: an expiry always leaves its flag set, even against a clear
  a_r10_expiry_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (|ch_exp) |=> ((stat_q & $past(ch_exp)) == $past(ch_exp)));

  // R9: cleared bits drop when no expiry competes
  a_r9_w1c_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stat && !(|ch_exp)) |=> ((stat_q & $past(w1c)) == '0));

  // R11: with no source of a pending flag the pin stays low
  a_r11_irq_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(stat_q) == '0 && $past(ch_exp) == '0) |-> !irq);
endmodule

// File: tb/test_tmr_block.sv
module test_tmr_block;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [3:0]  src_tick = '0;
  logic        irq;

  always #2 clk = ~clk;  // 250 MHz

  tmr_block i_tmr_block (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_addr (bus_addr),
    .bus_we   (bus_we),
    .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata),
    .src_tick (src_tick),
    .irq      (irq)
  );

  typedef struct {
    bit          is_irq;
    logic [31:0] exp;
    string       tag;
  } item_t;

  item_t q[$];
  int    n_cmp = 0;
  int    n_bad = 0;
  bit    pend  = 1'b0;
  bit    done  = 1'b0;
  int    cyc   = 0;

  // monitor: compares away from the rising edge
  always @(negedge clk) begin
    if (pend && q.size() > 0) begin
      item_t it;
      logic [31:0] act;
      it  = q.pop_front();
      act = it.is_irq ? {31'b0, irq} : bus_rdata;
      n_cmp++;
      if (act !== it.exp) begin
        n_bad++;
        $display("FAIL %s: got 0x%08h expected 0x%08h", it.tag, act, it.exp);
      end
      pend = 1'b0;
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000 && !done) begin
      done = 1'b1;
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(posedge clk); #1;
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(posedge clk); #1;
    bus_we = 1'b0;
  endtask

  task automatic wr_tick(input logic [7:0] a, input logic [31:0] d, input logic [3:0] m);
    @(posedge clk); #1;
    bus_addr = a; bus_wdata = d; bus_we = 1'b1; src_tick = m;
    @(posedge clk); #1;
    bus_we = 1'b0; src_tick = '0;
  endtask

  task automatic tick(input logic [3:0] m, input int n);
    for (int k = 0; k < n; k++) begin
      @(posedge clk); #1;
      src_tick = m;
      @(posedge clk); #1;
      src_tick = '0;
    end
  endtask

  task automatic rd(input logic [7:0] a, input logic [31:0] e, input string tag);
    item_t it;
    @(posedge clk); #1;
    bus_addr = a;
    it.is_irq = 1'b0; it.exp = e; it.tag = tag;
    q.push_back(it);
    pend = 1'b1;
  endtask

  task automatic chk_irq(input logic e, input string tag);
    item_t it;
    @(posedge clk); #1;
    it.is_irq = 1'b1; it.exp = {31'b0, e}; it.tag = tag;
    q.push_back(it);
    pend = 1'b1;
  endtask

  localparam logic [7:0] IEN = 8'h00, STAT = 8'h04;
  localparam logic [7:0] CTRL0 = 8'h10, INT0 = 8'h14, CNT0 = 8'h18;
  localparam logic [7:0] CTRL1 = 8'h20, INT1 = 8'h24, CNT1 = 8'h28;

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1 reset state
    rd(IEN, 0, "R1 ien");
    rd(STAT, 0, "R1 status");
    rd(CTRL0, 0, "R1 ctrl0");
    rd(CNT0, 0, "R1 count0");
    rd(INT1, 0, "R1 interval1");
    chk_irq(1'b0, "R1 irq");

    // R2 unmapped addresses
    wr(8'h08, 32'hFFFF_FFFF);
    rd(8'h08, 0, "R2 hole 0x08");
    wr(8'h1C, 32'h55);
    rd(8'h1C, 0, "R2 hole 0x1C");
    rd(8'h30, 0, "R2 page beyond channels");
    rd(CNT0, 0, "R2 count0 untouched");
    wr(INT0, 3);
    rd(INT0, 3, "R2 interval0");

    // R3 control fields and load bit
    wr(CTRL0, 32'hFF0F_0007);
    rd(CTRL0, 32'h5, "R3 ctrl0 readback");
    rd(CNT0, 3, "R3 load copies interval");

    // R4 source select and decrement
    tick(4'h1, 1);
    rd(CNT0, 3, "R4 other source ignored");
    tick(4'h2, 1);
    rd(CNT0, 2, "R4 decrement");
    tick(4'h2, 1);
    rd(CNT0, 1, "R4 decrement to 1");
    rd(STAT, 0, "R6 no flag before expiry");

    // R6 periodic expiry
    tick(4'h2, 1);
    rd(CNT0, 3, "R6 reload");
    rd(STAT, 1, "R6 flag set");
    chk_irq(1'b0, "R11 masked");
    wr(IEN, 1);
    chk_irq(1'b1, "R11 enabled");

    // R9 write-1-to-clear
    wr(STAT, 2);
    rd(STAT, 1, "R9 zero write keeps flag");
    wr(STAT, 1);
    rd(STAT, 0, "R9 one write clears");
    chk_irq(1'b0, "R11 cleared");

    // R10 clear against expiry
    tick(4'h2, 2);
    wr_tick(STAT, 1, 4'h2);
    rd(STAT, 1, "R10 expiry wins over clear");
    rd(CNT0, 3, "R10 reload");
    tick(4'h2, 2);
    wr_tick(STAT, 1, 4'h2);
    rd(STAT, 1, "R10 set flag stays");
    wr(STAT, 1);

    // R4 disabled channel holds
    wr(CTRL0, 0);
    tick(4'h2, 2);
    rd(CNT0, 3, "R4 disabled holds");

    // R5 divide by 4
    wr(INT1, 2);
    wr(CTRL1, 32'h2B);
    rd(CTRL1, 32'h29, "R3 ctrl1 readback");
    rd(CNT1, 2, "R3 load ch1");
    tick(4'h4, 3);
    rd(CNT1, 2, "R5 div4 before boundary");
    tick(4'h4, 1);
    rd(CNT1, 1, "R5 div4 boundary");

    // R8 direct count write, R5 divide by 16
    wr(CTRL1, 0);
    wr(CNT1, 5);
    rd(CNT1, 5, "R8 direct load");
    wr(CTRL1, 32'h49);
    tick(4'h4, 15);
    rd(CNT1, 5, "R5 div16 before boundary");
    tick(4'h4, 1);
    rd(CNT1, 4, "R5 div16 boundary");

    // R7 one-shot
    wr(CTRL1, 0);
    wr(CNT1, 2);
    wr(CTRL1, 32'h85);
    tick(4'h2, 1);
    rd(CNT1, 1, "R7 counting");
    tick(4'h2, 1);
    rd(CNT1, 0, "R7 parks at zero");
    rd(CTRL1, 32'h84, "R7 enable cleared");
    rd(STAT, 2, "R7 flag set");
    chk_irq(1'b0, "R11 ch1 masked");
    tick(4'h2, 1);
    rd(CNT1, 0, "R7 stays stopped");
    rd(CNT0, 3, "R4 ch0 still disabled");
    wr(IEN, 3);
    chk_irq(1'b1, "R11 ch1 enabled");
    wr(STAT, 2);
    chk_irq(1'b0, "R11 ch1 cleared");

    repeat (3) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule